// File: doc/BRIEF.md
# Dual-Mode Serial Bit-Rate Enable Generator

This block turns the system clock of an asynchronous serial channel into the single-cycle enables that pace its receiver and transmitter. A source tick comes from one of two internal dividers or from an external clock pin. The first divider is a fixed prescaler (10 or 30) followed by a power-of-two stage. The second is a programmable 16-bit time-constant divider with period 2×(TC+2). From the source tick the block derives a sample enable and a bit enable. The bit enable either follows every source tick (1x isochronous operation) or fires once every 16 or 64 source ticks (oversampled operation).

Internally the divider is a half-period counter. Each time it expires it toggles a square-wave clock-out pin, and every second expiry becomes a source tick. The time constant is written one byte at a time into a holding register. The counter picks up a new period, whether from a new time constant or a new mode setting, only when it reloads, so a period never comes out truncated. The external pin is synchronised to the system clock and edge-detected. Each of its rising edges then counts as one source tick.

Top module: `baud_clk_gen`

## Requirements
- R1: With `div_mode_i`=0 and `pow_sel_i`=S in 0..6, the source tick (seen as `samp_en_o`) repeats every B×2^S system cycles, where B=10 when `pre_sel_i`=0 and B=30 when `pre_sel_i`=1.
- R2: With `div_mode_i`=1, the source tick repeats every 2×(TC+2) system cycles, where TC is the 16-bit staged time constant.
- R3: A pulse on `tc_lo_we_i` stores `tc_byte_i` as TC bits 7:0, and a pulse on `tc_hi_we_i` stores it as bits 15:8. The counter takes in a new TC or divider setting only when a half period expires, so the half period in progress finishes at its old length.
- R4: With `iso_1x_i`=0, `bclk_en_o` pulses on every 16th source tick when `os_ratio_i`=0 and on every 64th when `os_ratio_i`=1. It is high only in a cycle where `samp_en_o` is high too.
- R5: With `iso_1x_i`=1, `bclk_en_o` pulses on every source tick, in the same cycle as `samp_en_o`.
- R6: With `div_mode_i`=0 and `pow_sel_i`=3'b111, the rising edges of `ext_clk_i` replace the internal divider as the source tick, and `clk_out_oe_o` is 0. In every other setting `clk_out_oe_o` is 1.
- R7: `clk_out_o` is a square wave. It stays high for half of the divider period and low for the other half (TC+2 cycles each in time-constant mode).
- R8: While `rst` is high at a clock edge, `samp_en_o`, `bclk_en_o` and `clk_out_o` are 0 after that edge and `clk_out_oe_o` is 1.
- R9: A rising edge of `ext_clk_i` that is set up before a clock edge gives exactly one `samp_en_o` pulse, visible after the third rising clock edge from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_mode_i | input | 1 | 0: prescale and power-of-two divider, 1: time-constant divider |
| pre_sel_i | input | 1 | Prescale choice, 0 for 10 and 1 for 30 |
| pow_sel_i | input | 3 | Power-of-two exponent, 3'b111 selects the external clock |
| os_ratio_i | input | 1 | Oversampling ratio, 0 for 16 and 1 for 64 |
| iso_1x_i | input | 1 | 1 gives a 1x bit clock |
| tc_byte_i | input | 8 | Time-constant byte to store |
| tc_lo_we_i | input | 1 | Store the byte as the low half of TC |
| tc_hi_we_i | input | 1 | Store the byte as the high half of TC |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| samp_en_o | output | 1 | Sample enable, one cycle per source tick |
| bclk_en_o | output | 1 | Bit-rate enable, one cycle per bit |
| clk_out_o | output | 1 | Square-wave clock for the clock pin |
| clk_out_oe_o | output | 1 | Output enable for the clock pin |

## Verification
If the half-period counter reloads with the wrong value, or picks up a new value at the wrong moment, the spacing of `samp_en_o` and the high time of `clk_out_o` show it within one divider period. A staged-TC test measures the exact interval that straddles a write made in the middle of a period. A bad oversampling count shows up as a wrong `bclk_en_o` spacing within one bit time, at most 64 source ticks. A flaw in the synchroniser or edge detector shows up within three cycles of an external edge, either as a shifted pulse or as a doubled one.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {DIV_LEGACY = 1'b0, DIV_TC = 1'b1} div_mode_e;
  localparam int POW_W       = 3;
  localparam logic [POW_W-1:0] EXT_CODE = '1;
  localparam int HALF_PRE_LO = 5;
  localparam int HALF_PRE_HI = 15;
  localparam int TC_OFFSET   = 2;
endpackage

// File: rtl/bcg_ext_sync.sv
module bcg_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R9: one pin edge never yields two adjacent ticks
  property p_single_rise;
    @(posedge clk) disable iff (rst) rise_o |=> !rise_o;
  endproperty
  assert_single_rise_R9: assert property (p_single_rise);
endmodule

// File: rtl/bcg_half_div.sv
module bcg_half_div
  import baud_pkg::*;
#(
  parameter int TC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  div_mode_e        mode_i,
  input  logic             pre_sel_i,
  input  logic [POW_W-1:0] pow_sel_i,
  input  logic [TC_W-1:0]  tc_i,
  output logic             gen_tick_o,
  output logic             clk_out_o
);
  localparam int CNT_W = TC_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] base;
  logic             term;
  logic             clk_q;

  always_comb begin
    base = pre_sel_i ? CNT_W'(HALF_PRE_HI) : CNT_W'(HALF_PRE_LO);
    if (mode_i == DIV_TC)
      reload = {1'b0, tc_i} + CNT_W'(TC_OFFSET - 1);
    else
      reload = (base << pow_sel_i) - CNT_W'(1);
  end

  assign term = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (term) begin
      cnt_q <= reload;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign gen_tick_o = term & clk_q;
  assign clk_out_o  = clk_q;

  // R2: shortest half period is two cycles
  property p_half_min;
    @(posedge clk) disable iff (rst) term |=> !term;
  endproperty
  assert_half_min_R2: assert property (p_half_min);

  // R1: shortest full period is four cycles
  property p_tick_gap;
    @(posedge clk) disable iff (rst)
      gen_tick_o |=> !gen_tick_o ##1 !gen_tick_o ##1 !gen_tick_o;
  endproperty
  assert_tick_gap_R1: assert property (p_tick_gap);
endmodule

// File: rtl/bcg_rate_div.sv
module bcg_rate_div #(
  parameter int OS_LO_LOG = 4,
  parameter int OS_HI_LOG = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic src_tick_i,
  input  logic os_ratio_i,
  input  logic iso_1x_i,
  output logic samp_en_o,
  output logic bclk_en_o
);
  localparam int OS_W = OS_HI_LOG;
  localparam logic [OS_W-1:0] LIM_LO = OS_W'((1 << OS_LO_LOG) - 1);
  localparam logic [OS_W-1:0] LIM_HI = OS_W'((1 << OS_HI_LOG) - 1);

  logic [OS_W-1:0] os_q;
  logic [OS_W-1:0] limit;
  logic            wrap;

  assign limit = os_ratio_i ? LIM_HI : LIM_LO;
  assign wrap  = (os_q >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      os_q      <= '0;
      samp_en_o <= 1'b0;
      bclk_en_o <= 1'b0;
    end else begin
      samp_en_o <= src_tick_i;
      bclk_en_o <= src_tick_i & (iso_1x_i | wrap);
      if (src_tick_i) os_q <= wrap ? '0 : os_q + OS_W'(1);
    end
  end

  // R4: a bit enable always rides on a sample enable
  property p_bit_on_samp;
    @(posedge clk) disable iff (rst) bclk_en_o |-> samp_en_o;
  endproperty
  assert_bit_on_samp_R4: assert property (p_bit_on_samp);

  // R5: in 1x mode both enables match
  property p_iso_match;
    @(posedge clk) disable iff (rst) $past(iso_1x_i) |-> (bclk_en_o == samp_en_o);
  endproperty
  assert_iso_match_R5: assert property (p_iso_match);

  // R8: quiet outputs after any reset edge
  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= rst;
  always @(negedge clk) begin
    if (rst_seen_q) begin
      assert_reset_quiet_R8: assert (!samp_en_o && !bclk_en_o);
    end
  end
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OS_LO_LOG   = 4,
  parameter int OS_HI_LOG   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div_mode_i,
  input  logic              pre_sel_i,
  input  logic [POW_W-1:0]  pow_sel_i,
  input  logic              os_ratio_i,
  input  logic              iso_1x_i,
  input  logic [BYTE_W-1:0] tc_byte_i,
  input  logic              tc_lo_we_i,
  input  logic              tc_hi_we_i,
  input  logic              ext_clk_i,
  output logic              samp_en_o,
  output logic              bclk_en_o,
  output logic              clk_out_o,
  output logic              clk_out_oe_o
);
  localparam int TC_W = 2 * BYTE_W;

  logic [TC_W-1:0] tc_q;
  logic            gen_tick;
  logic            ext_rise;
  logic            ext_sel;
  logic            src_tick;
  div_mode_e       mode;

  assign mode    = div_mode_e'(div_mode_i);
  assign ext_sel = (mode == DIV_LEGACY) && (pow_sel_i == EXT_CODE);
  assign src_tick = ext_sel ? ext_rise : gen_tick;

  // staged time constant, consumed by the counter only at reload
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q <= '0;
    end else begin
      if (tc_lo_we_i) tc_q[BYTE_W-1:0]    <= tc_byte_i;
      if (tc_hi_we_i) tc_q[TC_W-1:BYTE_W] <= tc_byte_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_out_oe_o <= 1'b1;
    else     clk_out_oe_o <= ~ext_sel;
  end

  bcg_half_div #(.TC_W(TC_W)) u_half (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .pre_sel_i  (pre_sel_i),
    .pow_sel_i  (pow_sel_i),
    .tc_i       (tc_q),
    .gen_tick_o (gen_tick),
    .clk_out_o  (clk_out_o)
  );

  bcg_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (ext_clk_i),
    .rise_o (ext_rise)
  );

  bcg_rate_div #(.OS_LO_LOG(OS_LO_LOG), .OS_HI_LOG(OS_HI_LOG)) u_rate (
    .clk        (clk),
    .rst        (rst),
    .src_tick_i (src_tick),
    .os_ratio_i (os_ratio_i),
    .iso_1x_i   (iso_1x_i),
    .samp_en_o  (samp_en_o),
    .bclk_en_o  (bclk_en_o)
  );

  // R6: external source disables the clock pin driver
  property p_ext_oe;
    @(posedge clk) disable iff (rst) ext_sel |=> !clk_out_oe_o;
  endproperty
  assert_ext_oe_R6: assert property (p_ext_oe);
endmodule

// File: tb/sim_baud_clk_gen.sv
module sim_baud_clk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_mode = 1'b0, pre_sel = 1'b0, os_ratio = 1'b0, iso_1x = 1'b0;
  logic [2:0] pow_sel = 3'd0;
  logic [7:0] tc_byte = 8'd0;
  logic       tc_lo_we = 1'b0, tc_hi_we = 1'b0, ext_clk = 1'b0;
  logic       samp_en, bclk_en, clk_out, clk_out_oe;
  logic       ext_run = 1'b0;

  int checks = 0;
  int failures = 0;
  localparam int WAIT_LIMIT = 60000;

  always #10 clk = ~clk;

  baud_clk_gen u0 (
    .clk(clk), .rst(rst), .div_mode_i(div_mode), .pre_sel_i(pre_sel),
    .pow_sel_i(pow_sel), .os_ratio_i(os_ratio), .iso_1x_i(iso_1x),
    .tc_byte_i(tc_byte), .tc_lo_we_i(tc_lo_we), .tc_hi_we_i(tc_hi_we),
    .ext_clk_i(ext_clk), .samp_en_o(samp_en), .bclk_en_o(bclk_en),
    .clk_out_o(clk_out), .clk_out_oe_o(clk_out_oe)
  );

  typedef struct packed {
    logic        mode;
    logic        pre;
    logic [2:0]  pow;
    logic        os;
    logic        iso;
    logic [15:0] tc;
    logic [31:0] samp_gap;
    logic [31:0] bit_gap;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'd0,   32'd10,  32'd160},
    '{1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 16'd0,   32'd30,  32'd480},
    '{1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 16'd0,   32'd40,  32'd640},
    '{1'b0, 1'b0, 3'd3, 1'b1, 1'b0, 16'd0,   32'd80,  32'd5120},
    '{1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 16'd0,   32'd60,  32'd60},
    '{1'b0, 1'b0, 3'd6, 1'b0, 1'b1, 16'd0,   32'd640, 32'd640},
    '{1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'd3,   32'd10,  32'd160},
    '{1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'd0,   32'd4,   32'd64},
    '{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 16'd10,  32'd24,  32'd24},
    '{1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'd300, 32'd604, 32'd9664}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until the chosen enable is high
  task automatic wait_pulse(input bit use_bit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(use_bit ? bclk_en : samp_en) && n < WAIT_LIMIT);
  endtask

  task automatic write_tc(input logic [15:0] v);
    @(negedge clk); tc_lo_we = 1'b1; tc_byte = v[7:0];
    @(negedge clk); tc_lo_we = 1'b0; tc_hi_we = 1'b1; tc_byte = v[15:8];
    @(negedge clk); tc_hi_we = 1'b0;
  endtask

  initial begin : ext_driver
    forever begin
      @(negedge clk);
      if (ext_run) begin
        repeat (3) @(negedge clk);
        ext_clk = ~ext_clk;
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int n, gap;
    // R8 reset state
    repeat (4) @(negedge clk);
    chk("R8 samp in reset", int'(samp_en), 0);
    chk("R8 bclk in reset", int'(bclk_en), 0);
    chk("R8 clk_out in reset", int'(clk_out), 0);
    chk("R8 oe in reset", int'(clk_out_oe), 1);
    rst = 1'b0;

    // table walk: R1 R2 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      div_mode = VECS[i].mode; pre_sel = VECS[i].pre; pow_sel = VECS[i].pow;
      os_ratio = VECS[i].os;   iso_1x = VECS[i].iso;
      write_tc(VECS[i].tc);
      wait_pulse(1'b0, n); wait_pulse(1'b0, n); wait_pulse(1'b0, n);
      wait_pulse(1'b0, gap);
      chk(VECS[i].mode ? "R2 samp gap" : "R1 samp gap", gap, int'(VECS[i].samp_gap));
      wait_pulse(1'b1, n); wait_pulse(1'b1, n);
      wait_pulse(1'b1, gap);
      chk(VECS[i].iso ? "R5 bit gap" : "R4 bit gap", gap, int'(VECS[i].bit_gap));
      chk("R6 oe internal", int'(clk_out_oe), 1);
    end

    // R7 clock-out high time, TC=3 gives 5 cycles
    @(negedge clk);
    div_mode = 1'b1; iso_1x = 1'b1; os_ratio = 1'b0;
    write_tc(16'd3);
    repeat (30) @(negedge clk);
    while (clk_out) @(negedge clk);
    while (!clk_out) @(negedge clk);
    n = 0;
    while (clk_out) begin n++; @(negedge clk); end
    chk("R7 high time", n, 5);
    n = 0;
    while (!clk_out) begin n++; @(negedge clk); end
    chk("R7 low time", n, 5);

    // R3 staged TC: write mid period, old half completes
    write_tc(16'd50);
    repeat (3) wait_pulse(1'b0, n);
    repeat (10) @(negedge clk);
    write_tc(16'd0);
    wait_pulse(1'b0, n);
    chk("R3 straddling gap", 13 + n, 54);
    wait_pulse(1'b0, gap);
    chk("R3 new gap", gap, 4);

    // R3 high byte alone changes the period: TC=0x0100 -> 516
    @(negedge clk); tc_hi_we = 1'b1; tc_byte = 8'h01;
    @(negedge clk); tc_hi_we = 1'b0;
    repeat (3) wait_pulse(1'b0, n);
    wait_pulse(1'b0, gap);
    chk("R3 high byte gap", gap, 516);

    // R6 R9 external source
    @(negedge clk);
    div_mode = 1'b0; pow_sel = 3'b111; iso_1x = 1'b1; ext_clk = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 oe external", int'(clk_out_oe), 0);
    chk("R6 no internal ticks", int'(samp_en), 0);
    ext_clk = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!samp_en && n < 20);
    chk("R9 sync latency", n, 3);
    @(negedge clk);
    chk("R9 single pulse", int'(samp_en), 0);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
    ext_run = 1'b1;
    repeat (3) wait_pulse(1'b1, n);
    wait_pulse(1'b1, gap);
    chk("R6 ext 1x bit gap", gap, 8);
    iso_1x = 1'b0;
    repeat (2) wait_pulse(1'b1, n);
    wait_pulse(1'b1, gap);
    chk("R4 ext x16 bit gap", gap, 128);
    wait_pulse(1'b0, gap);
    chk("R6 ext samp gap", gap, 8);
    ext_run = 1'b0;

    // R8 mid-run reset clears outputs
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R8 samp after reset", int'(samp_en), 0);
    chk("R8 oe after reset", int'(clk_out_oe), 1);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule